// File: doc/BRIEF.md
# Active Window Timing Generator

This block marks the active part of a raster that arrives as two enable levels: a line enable that is high while a line carries pixels, and a frame enable that is high while a frame carries lines. Each rise of the line enable restarts a pixel count. Each rise of the frame enable restarts a line count, which then steps once for every line-enable rise. A pixel is windowed when it lies past a programmable horizontal delay and a programmable vertical delay, and inside a programmable active width and height.

The outputs are registered. The window flag rises one clock after the edge that samples the first qualified pixel. The column index and the line index give the pixel's position inside the window, counted from zero. Both indices read zero whenever the window is low.

Top module: `winGen`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `window`, `column` and `line` are all 0. Asserting `rstN` low mid-run clears them without waiting for a clock edge.
- R2: The first clock edge that samples `hEnable` high after a low sample is pixel 0. Each later edge with `hEnable` high is the next pixel. `window` is high in the cycle after the edge of pixel `hDelay` on a qualified line.
- R3: On a qualified line, `window` stays high for `activeWidth` consecutive cycles. It goes low one cycle after an edge that samples `hEnable` low, even if this comes earlier.
- R4: A line is counted at each clock edge where `hEnable` rises while `vEnable` is high. The first such line after a `vEnable` rise is line 0. Only lines `vDelay` through `vDelay+activeHeight-1` are qualified.
- R5: A new rise of `vEnable` restarts line counting at 0, even if earlier lines of the frame were counted.
- R6: While `window` is high, `column` equals pixel number minus `hDelay`, so it runs 0 to `activeWidth-1` and increments by 1 each cycle. It is 0 whenever `window` is low.
- R7: While `window` is high, `line` equals line number minus `vDelay`. It is 0 whenever `window` is low.
- R8: With `activeWidth` or `activeHeight` equal to 0, `window` never rises.
- R9: An edge that samples `vEnable` low drives `window` low in the next cycle. The current line stays disqualified until a new line is counted.
- R10: With `hDelay` equal to 0, `window` rises in the cycle right after the edge that first samples `hEnable` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| hEnable | input | 1 | Line enable, active high |
| vEnable | input | 1 | Frame enable, active high |
| hDelay | input | CNT_W | Pixels skipped at the start of each line |
| vDelay | input | CNT_W | Lines skipped at the start of each frame |
| activeWidth | input | CNT_W | Windowed pixels per line |
| activeHeight | input | CNT_W | Windowed lines per frame |
| window | output | 1 | Active-area flag |
| column | output | CNT_W | Pixel index inside the window |
| line | output | CNT_W | Line index inside the window |

## Verification
The hardest cases to reach are the ones where the frame enable moves against the line cadence. These are `vEnable` falling in the middle of a windowed line, and `vEnable` rising again partway through a frame, so the line count must restart. The stimulus produces both on purpose, with short lines and small delays so the edge falls inside a window. A second scenario uses a line shorter than `hDelay+activeWidth`, so the window is cut short by the line enable.

// File: rtl/winGenPkg.sv
package winGenPkg;

  typedef struct packed {
    logic hRise;
    logic vRise;
    logic pixStep;
    logic lineStep;
    logic load;
  } winStrobes_t;

  function automatic logic inSpan(input logic [15:0] pos, input logic [15:0] start,
                                  input logic [15:0] span);
    logic [16:0] stop;
    stop = {1'b0, start} + {1'b0, span};
    return ({1'b0, pos} >= {1'b0, start}) && ({1'b0, pos} < stop);
  endfunction

endpackage

// File: rtl/winGenDatapath.sv
module winGenDatapath
  import winGenPkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  winStrobes_t      strobes,
  input  logic [CNT_W-1:0] hDelay,
  input  logic [CNT_W-1:0] vDelay,
  output logic [CNT_W-1:0] pixNow,
  output logic [CNT_W-1:0] lineNow,
  output logic [CNT_W-1:0] column,
  output logic [CNT_W-1:0] line
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] hPos;
  logic [CNT_W-1:0] vPos;
  logic [CNT_W-1:0] curLine;
  logic [CNT_W-1:0] lineSel;

  assign pixNow  = strobes.hRise ? '0 : hPos;
  assign lineSel = strobes.vRise ? '0 : vPos;
  assign lineNow = strobes.lineStep ? lineSel : curLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPos <= '0;
    end else if (strobes.pixStep) begin
      hPos <= (pixNow == CNT_MAX) ? CNT_MAX : pixNow + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPos    <= '0;
      curLine <= '0;
    end else if (strobes.lineStep) begin
      vPos    <= (lineSel == CNT_MAX) ? CNT_MAX : lineSel + 1'b1;
      curLine <= lineSel;
    end else if (strobes.vRise) begin
      vPos <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      column <= '0;
      line   <= '0;
    end else if (strobes.load) begin
      column <= pixNow - hDelay;
      line   <= lineNow - vDelay;
    end else begin
      column <= '0;
      line   <= '0;
    end
  end

  AST_PIX_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hRise |=> (hPos == CNT_W'(1))) else $error("pixel count did not restart"); // R2

endmodule

// File: rtl/winGenControl.sv
module winGenControl
  import winGenPkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hEnable,
  input  logic             vEnable,
  input  logic [CNT_W-1:0] hDelay,
  input  logic [CNT_W-1:0] vDelay,
  input  logic [CNT_W-1:0] activeWidth,
  input  logic [CNT_W-1:0] activeHeight,
  input  logic [CNT_W-1:0] pixNow,
  input  logic [CNT_W-1:0] lineNow,
  output winStrobes_t      strobes,
  output logic             window
);

  logic hPrev;
  logic vPrev;
  logic lineActive;
  logic lineOkNow;
  logic pixOkNow;
  logic windowNext;

  always_comb begin
    strobes          = '0;
    strobes.hRise    = hEnable & ~hPrev;
    strobes.vRise    = vEnable & ~vPrev;
    strobes.pixStep  = hEnable;
    strobes.lineStep = strobes.hRise & vEnable;

    if (strobes.lineStep) begin
      lineOkNow = inSpan(16'(lineNow), 16'(vDelay), 16'(activeHeight));
    end else if (strobes.vRise || !vEnable) begin
      lineOkNow = 1'b0;
    end else begin
      lineOkNow = lineActive;
    end

    pixOkNow     = inSpan(16'(pixNow), 16'(hDelay), 16'(activeWidth));
    windowNext   = hEnable & vEnable & lineOkNow & pixOkNow;
    strobes.load = windowNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPrev      <= 1'b0;
      vPrev      <= 1'b0;
      lineActive <= 1'b0;
      window     <= 1'b0;
    end else begin
      hPrev      <= hEnable;
      vPrev      <= vEnable;
      lineActive <= lineOkNow;
      window     <= windowNext;
    end
  end

  AST_WIN_NEEDS_HEN: assert property (@(posedge clk) disable iff (!rstN)
    !hEnable |=> !window) else $error("window without line enable"); // R3
  AST_WIN_NEEDS_VEN: assert property (@(posedge clk) disable iff (!rstN)
    !vEnable |=> !window) else $error("window without frame enable"); // R9
  AST_ZERO_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    (activeWidth == '0 || activeHeight == '0) |=> !window) else $error("window with zero span"); // R8

endmodule

// File: rtl/winGen.sv
module winGen
  import winGenPkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hEnable,
  input  logic             vEnable,
  input  logic [CNT_W-1:0] hDelay,
  input  logic [CNT_W-1:0] vDelay,
  input  logic [CNT_W-1:0] activeWidth,
  input  logic [CNT_W-1:0] activeHeight,
  output logic             window,
  output logic [CNT_W-1:0] column,
  output logic [CNT_W-1:0] line
);

  winStrobes_t      strobes;
  logic [CNT_W-1:0] pixNow;
  logic [CNT_W-1:0] lineNow;

  winGenControl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .hEnable(hEnable), .vEnable(vEnable),
    .hDelay(hDelay), .vDelay(vDelay), .activeWidth(activeWidth),
    .activeHeight(activeHeight), .pixNow(pixNow), .lineNow(lineNow),
    .strobes(strobes), .window(window)
  );

  winGenDatapath #(.CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hDelay(hDelay),
    .vDelay(vDelay), .pixNow(pixNow), .lineNow(lineNow),
    .column(column), .line(line)
  );

  AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    window |-> (column < activeWidth)) else $error("column out of range"); // R6
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (window && $past(window)) |-> (column == CNT_W'($past(column) + 1'b1))) else $error("column skipped"); // R6
  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    window |-> (line < activeHeight)) else $error("line out of range"); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !window |-> (column == '0 && line == '0)) else $error("index not zero outside window"); // R6

endmodule

// File: tb/winGen_test.sv
module winGen_test;

  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             hEnable = 1'b0;
  logic             vEnable = 1'b0;
  logic [CNT_W-1:0] hDelay = '0;
  logic [CNT_W-1:0] vDelay = '0;
  logic [CNT_W-1:0] activeWidth = '0;
  logic [CNT_W-1:0] activeHeight = '0;
  logic             window;
  logic [CNT_W-1:0] column;
  logic [CNT_W-1:0] line;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    logic             w;
    logic [CNT_W-1:0] c;
    logic [CNT_W-1:0] l;
    string            tag;
  } expItem_t;

  expItem_t expQ[$];

  // reference state
  logic mPrevH, mPrevV, mAct;
  int   mHPos, mVPos, mCur;

  winGen #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .hEnable(hEnable), .vEnable(vEnable),
    .hDelay(hDelay), .vDelay(vDelay), .activeWidth(activeWidth),
    .activeHeight(activeHeight), .window(window), .column(column), .line(line)
  );

  always #2 clk = ~clk;

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog R1 actual hung expected finished");
      finishRun();
    end
  end

  task automatic modelReset();
    mPrevH = 0; mPrevV = 0; mAct = 0;
    mHPos = 0; mVPos = 0; mCur = 0;
  endtask

  function automatic logic inRange(int pos, int start, int span);
    return (pos >= start) && (pos < start + span);
  endfunction

  // drive one cycle and push the expected registered result
  task automatic drive(input logic h, input logic v, input string tag);
    expItem_t it;
    logic hR, vR, step, win;
    int p, l;
    @(negedge clk);
    hEnable = h;
    vEnable = v;
    hR = h & ~mPrevH;
    vR = v & ~mPrevV;
    p = hR ? 0 : mHPos;
    l = vR ? 0 : mVPos;
    step = hR & v;
    if (step) begin
      mAct = inRange(l, int'(vDelay), int'(activeHeight));
      mCur = l;
    end else if (vR || !v) begin
      mAct = 0;
    end
    win = h & v & mAct & inRange(p, int'(hDelay), int'(activeWidth));
    it.w = win;
    it.c = win ? CNT_W'(p - int'(hDelay)) : '0;
    it.l = win ? CNT_W'(mCur - int'(vDelay)) : '0;
    it.tag = tag;
    expQ.push_back(it);
    if (h) mHPos = p + 1;
    if (step) mVPos = l + 1;
    else if (vR) mVPos = 0;
    mPrevH = h;
    mPrevV = v;
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (window !== e.w || column !== e.c || line !== e.l) begin
        errors++;
        $display("FAIL %s actual w=%0b c=%0d l=%0d expected w=%0b c=%0d l=%0d",
                 e.tag, window, column, line, e.w, e.c, e.l);
      end
    end
  end

  task automatic setParams(int hd, int vd, int wd, int ht);
    @(negedge clk);
    hDelay = CNT_W'(hd); vDelay = CNT_W'(vd);
    activeWidth = CNT_W'(wd); activeHeight = CNT_W'(ht);
  endtask

  task automatic runFrame(int nLines, int lineLen, input string tag);
    drive(0, 1, tag);
    for (int i = 0; i < nLines; i++) begin
      for (int k = 0; k < lineLen; k++) drive(1, 1, tag);
      drive(0, 1, tag);
      drive(0, 1, tag);
    end
    drive(0, 0, tag);
    drive(0, 0, tag);
  endtask

  task automatic checkIdle(input string tag);
    checks++;
    if (window !== 1'b0 || column !== '0 || line !== '0) begin
      errors++;
      $display("FAIL %s actual w=%0b c=%0d l=%0d expected w=0 c=0 l=0",
               tag, window, column, line);
    end
  endtask

  initial begin
    modelReset();
    #1;
    checkIdle("R1 during reset");
    repeat (3) @(negedge clk);
    checkIdle("R1 before release");
    rstN = 1'b1;
    @(posedge clk); #1;
    checkIdle("R1 after release");

    // R2 R4 R6 R7: delays with full-length lines
    setParams(3, 1, 4, 2);
    runFrame(4, 9, "R2 R4 R6 R7 delayed window");

    // R10: zero delays
    setParams(0, 0, 3, 3);
    runFrame(3, 5, "R10 zero delay");

    // R3: line ends before the window is full
    setParams(2, 0, 10, 2);
    runFrame(2, 6, "R3 early line end");

    // R8: zero width, then zero height
    setParams(0, 0, 0, 3);
    runFrame(2, 4, "R8 zero width");
    setParams(0, 0, 3, 0);
    runFrame(2, 4, "R8 zero height");

    // R9: frame enable drops mid-line, returns inside the same line
    setParams(1, 0, 5, 4);
    drive(0, 1, "R9 setup");
    for (int k = 0; k < 3; k++) drive(1, 1, "R9 before drop");
    drive(1, 0, "R9 drop");
    drive(1, 0, "R9 dropped");
    for (int k = 0; k < 3; k++) drive(1, 1, "R9 back high same line");
    drive(0, 1, "R9 gap");
    for (int k = 0; k < 6; k++) drive(1, 1, "R9 R5 fresh line");
    drive(0, 0, "R9 end");

    // R5: frame enable rises again partway through a frame
    setParams(0, 2, 2, 2);
    drive(0, 1, "R5 setup");
    for (int i = 0; i < 2; i++) begin
      for (int k = 0; k < 3; k++) drive(1, 1, "R5 skipped line");
      drive(0, 1, "R5 gap");
    end
    drive(0, 0, "R5 low");
    drive(0, 1, "R5 rise again");
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 3; k++) drive(1, 1, "R5 restarted count");
      drive(0, 1, "R5 gap");
    end
    drive(0, 0, "R5 end");

    // R1: asynchronous reset in the middle of a window
    setParams(0, 0, 8, 2);
    drive(0, 1, "R1 setup");
    drive(1, 1, "R1 setup");
    drive(1, 1, "R1 setup");
    @(negedge clk);
    rstN = 1'b0;
    hEnable = 1'b1;
    #1;
    checkIdle("R1 async reset");
    modelReset();
    @(negedge clk);
    hEnable = 1'b0;
    vEnable = 1'b0;
    rstN = 1'b1;
    setParams(1, 0, 2, 1);
    runFrame(2, 4, "R1 R2 after reset");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule